// File: doc/BRIEF.md
# Load Address and Data Formatting Unit

This unit sits in the load path of a 32-bit big-endian integer pipeline. For each decoded load it forms the effective address and checks it for natural alignment. It also checks an update-form load for a legal register encoding. When a load passes both checks, the unit issues one memory read and waits for the returned word. It then extracts and extends the addressed byte, half word or word and presents the value for the destination register. For update forms it also presents the effective address for a write to the base register.

Only one load is in flight at a time. The unit lowers `in_ready` from acceptance until completion, so loads are accepted, addressed and completed strictly in the order they arrive. A load that is misaligned or illegally encoded never reaches memory. It completes with a flag raised and no register write enabled. The register file, the memory system and exception handling lie outside the unit.

Top module: `ld_fmt_unit`

## Requirements
- R1: The effective address is `in_base + sext(in_disp)` when `in_mode`=0, `in_base + in_index` when `in_mode`=1, and `in_base` alone when `in_mode` is 2 or 3. The sum is taken modulo 2^32.
- R2: `in_kind`=0 is a byte load. The result is the byte at offset EA[1:0] of the big-endian memory word, zero-extended. Offset 0 is bits [31:24] and offset 3 is bits [7:0].
- R3: `in_kind`=1 is a half-word load with zero extension. The half word is bits [31:16] when EA[1]=0 and bits [15:0] when EA[1]=1.
- R4: `in_kind`=2 is a half-word load with sign extension. The half word is selected as in R3, and its bit 15 is copied into result bits [31:16].
- R5: `in_kind`=3 is a word load. The result is the memory word unchanged.
- R6: When `in_update`=1 and the load completes normally, `wb_ra_we` is 1 and `wb_ra_data` equals the effective address. When `in_update`=0, `wb_ra_we` stays 0.
- R7: A load is misaligned when it is a half word (kind 1 or 2) with EA[0]=1, or a word with EA[1:0]≠0. A misaligned load raises `wb_misalign`, issues no memory request and enables no register write.
- R8: An update-form load whose base index is 0, or whose base index equals its destination index, raises `wb_illegal`, issues no memory request and enables no register write.
- R9: `mem_req_valid` rises the cycle after acceptance. The address and size (`mem_req_size` 0=byte, 1=half, 2=word) hold steady until `mem_req_ready`. `in_ready` stays low from acceptance until the completion cycle has passed.
- R10: `wb_valid` is high for exactly one cycle. For a normal load that cycle is the one after the clock edge that samples `mem_rsp_valid`. For a faulting load it is the cycle after acceptance.
- R11: After reset, `in_ready`=1 and `mem_req_valid`=0 and `wb_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A decoded load is offered |
| in_ready | output | 1 | Unit is idle and takes the offered load |
| in_kind | input | 2 | 0 byte, 1 half zero-ext, 2 half sign-ext, 3 word |
| in_mode | input | 2 | 0 base+disp, 1 base+index, 2/3 base only |
| in_update | input | 1 | Update form: write EA back to the base register |
| in_ra | input | RIDX_W | Base register index |
| in_rd | input | RIDX_W | Destination register index |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| in_disp | input | DISP_W | Signed displacement |
| mem_req_valid | output | 1 | Memory read request pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Request address (effective address) |
| mem_req_size | output | 2 | 0 byte, 1 half, 2 word |
| mem_rsp_valid | input | 1 | Returned word valid |
| mem_rsp_data | input | 32 | Returned big-endian word |
| wb_valid | output | 1 | Completion, one cycle |
| wb_rd_we | output | 1 | Write destination register |
| wb_rd_idx | output | RIDX_W | Destination index |
| wb_rd_data | output | 32 | Formatted load result |
| wb_ra_we | output | 1 | Write base register |
| wb_ra_idx | output | RIDX_W | Base index |
| wb_ra_data | output | 32 | Effective address for the base register |
| wb_misalign | output | 1 | Completion carries a misalignment fault |
| wb_illegal | output | 1 | Completion carries an illegal update encoding |

## Verification
The request is due in the cycle after acceptance and stays there for as long as the bench holds `mem_req_ready` low. The completion is due in the cycle after the edge that samples `mem_rsp_valid`. A faulting load completes in the cycle after acceptance. The bench drives and samples on the falling edge and waits a random 0 to 3 cycles on each side. At each falling edge it checks exactly the outputs the requirements fix for that cycle, which includes the idle cycles of a stalled handshake. It checks `in_ready` again one cycle after each completion.

// File: rtl/ldf_pkg.sv
package ldf_pkg;
  localparam int XLEN = 32;

  typedef enum logic [1:0] {LK_BYTE = 2'd0, LK_HALF_Z = 2'd1, LK_HALF_S = 2'd2, LK_WORD = 2'd3} ld_kind_e;
  typedef enum logic [1:0] {AM_DISP = 2'd0, AM_INDEX = 2'd1, AM_BASE = 2'd2, AM_BASE2 = 2'd3} ld_mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} ld_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  function automatic logic [XLEN-1:0] ldf_ea(ld_mode_e m, logic [XLEN-1:0] base,
                                             logic [XLEN-1:0] idx, logic [XLEN-1:0] dsx);
    case (m)
      AM_DISP:  return base + dsx;
      AM_INDEX: return base + idx;
      default:  return base;
    endcase
  endfunction

  function automatic logic [1:0] ldf_size(ld_kind_e k);
    case (k)
      LK_BYTE: return SZ_BYTE;
      LK_WORD: return SZ_WORD;
      default: return SZ_HALF;
    endcase
  endfunction

  function automatic logic ldf_misaligned(ld_kind_e k, logic [1:0] low);
    case (k)
      LK_BYTE: return 1'b0;
      LK_WORD: return |low;
      default: return low[0];
    endcase
  endfunction

  function automatic logic [XLEN-1:0] ldf_format(ld_kind_e k, logic [1:0] off, logic [XLEN-1:0] raw);
    logic [XLEN-1:0] bsh;
    logic [XLEN-1:0] hsh;
    bsh = raw << {off, 3'b000};
    hsh = raw << {off[1], 4'b0000};
    case (k)
      LK_BYTE:   return {{(XLEN-8){1'b0}}, bsh[XLEN-1 -: 8]};
      LK_HALF_Z: return {{(XLEN-16){1'b0}}, hsh[XLEN-1 -: 16]};
      LK_HALF_S: return {{(XLEN-16){hsh[XLEN-1]}}, hsh[XLEN-1 -: 16]};
      default:   return raw;
    endcase
  endfunction
endpackage

// File: rtl/ldf_agen.sv
module ldf_agen
  import ldf_pkg::*;
#(
  parameter int RIDX_W = 5,
  parameter int DISP_W = 16
) (
  input  ld_kind_e             kind,
  input  ld_mode_e             mode,
  input  logic                 update,
  input  logic [RIDX_W-1:0]    ra,
  input  logic [RIDX_W-1:0]    rd,
  input  logic [XLEN-1:0]      base,
  input  logic [XLEN-1:0]      index,
  input  logic [DISP_W-1:0]    disp,
  output logic [XLEN-1:0]      ea,
  output logic                 misalign,
  output logic                 illegal
);
  localparam int EXT_W = XLEN - DISP_W;

  logic [XLEN-1:0] disp_sx;

  assign disp_sx  = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign ea       = ldf_ea(mode, base, index, disp_sx);
  assign misalign = ldf_misaligned(kind, ea[1:0]);
  assign illegal  = update && ((ra == '0) || (ra == rd));
endmodule

// File: rtl/ldf_format.sv
module ldf_format
  import ldf_pkg::*;
(
  input  ld_kind_e        kind,
  input  logic [1:0]      offset,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] result
);
  assign result = ldf_format(kind, offset, raw);
endmodule

// File: rtl/ld_fmt_unit.sv
module ld_fmt_unit
  import ldf_pkg::*;
#(
  parameter int RIDX_W = 5,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [1:0]        in_mode,
  input  logic              in_update,
  input  logic [RIDX_W-1:0] in_ra,
  input  logic [RIDX_W-1:0] in_rd,
  input  logic [XLEN-1:0]   in_base,
  input  logic [XLEN-1:0]   in_index,
  input  logic [DISP_W-1:0] in_disp,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic [1:0]        mem_req_size,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              wb_valid,
  output logic              wb_rd_we,
  output logic [RIDX_W-1:0] wb_rd_idx,
  output logic [XLEN-1:0]   wb_rd_data,
  output logic              wb_ra_we,
  output logic [RIDX_W-1:0] wb_ra_idx,
  output logic [XLEN-1:0]   wb_ra_data,
  output logic              wb_misalign,
  output logic              wb_illegal
);
  ld_state_e         st;
  ld_kind_e          kind_q;
  logic [XLEN-1:0]   ea_q, res_q;
  logic [RIDX_W-1:0] ra_q, rd_q;
  logic              upd_q, mis_q, ill_q;

  logic [XLEN-1:0]   ea_c, fmt_c;
  logic              mis_c, ill_c;

  // named events
  logic accept_evt, fault_evt, req_fire, rsp_fire, fault_q;

  ldf_agen #(.RIDX_W(RIDX_W), .DISP_W(DISP_W)) u_agen (
    .kind(ld_kind_e'(in_kind)), .mode(ld_mode_e'(in_mode)), .update(in_update),
    .ra(in_ra), .rd(in_rd), .base(in_base), .index(in_index), .disp(in_disp),
    .ea(ea_c), .misalign(mis_c), .illegal(ill_c)
  );

  ldf_format u_fmt (
    .kind(kind_q), .offset(ea_q[1:0]), .raw(mem_rsp_data), .result(fmt_c)
  );

  assign accept_evt = in_valid && (st == ST_IDLE);
  assign fault_evt  = accept_evt && (mis_c || ill_c);
  assign req_fire   = (st == ST_REQ) && mem_req_ready;
  assign rsp_fire   = (st == ST_WAIT) && mem_rsp_valid;
  assign fault_q    = mis_q || ill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      kind_q <= LK_BYTE;
      ea_q   <= '0;
      res_q  <= '0;
      ra_q   <= '0;
      rd_q   <= '0;
      upd_q  <= 1'b0;
      mis_q  <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept_evt) begin
          kind_q <= ld_kind_e'(in_kind);
          ea_q   <= ea_c;
          ra_q   <= in_ra;
          rd_q   <= in_rd;
          upd_q  <= in_update;
          mis_q  <= mis_c;
          ill_q  <= ill_c;
          st     <= fault_evt ? ST_DONE : ST_REQ;
        end
        ST_REQ:  if (req_fire) st <= ST_WAIT;
        ST_WAIT: if (rsp_fire) begin
          res_q <= fmt_c;
          st    <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign in_ready      = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_REQ);
  assign mem_req_addr  = ea_q;
  assign mem_req_size  = ldf_size(kind_q);
  assign wb_valid      = (st == ST_DONE);
  assign wb_rd_we      = wb_valid && !fault_q;
  assign wb_ra_we      = wb_rd_we && upd_q;
  assign wb_rd_idx     = rd_q;
  assign wb_rd_data    = res_q;
  assign wb_ra_idx     = ra_q;
  assign wb_ra_data    = ea_q;
  assign wb_misalign   = wb_valid && mis_q;
  assign wb_illegal    = wb_valid && ill_q;
endmodule

// File: rtl/ldf_checker.sv
module ldf_checker #(
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [31:0]       mem_req_addr,
  input logic [1:0]        mem_req_size,
  input logic              mem_rsp_valid,
  input logic              wb_valid,
  input logic              wb_rd_we,
  input logic [RIDX_W-1:0] wb_rd_idx,
  input logic [31:0]       wb_rd_data,
  input logic              wb_ra_we,
  input logic [RIDX_W-1:0] wb_ra_idx,
  input logic              wb_misalign,
  input logic              wb_illegal
);
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size)); // R9

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, mem_req_valid, wb_valid})); // R9

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !((mem_req_size == 2'd1) && mem_req_addr[0]) &&
                      !((mem_req_size == 2'd2) && (mem_req_addr[1:0] != 2'd0))); // R7

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && (wb_misalign || wb_illegal) |-> !wb_rd_we && !wb_ra_we); // R7

  AST_UPDATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ra_we |-> (wb_ra_idx != '0) && (wb_ra_idx != wb_rd_idx)); // R8

  AST_WB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid && in_ready); // R10

  AST_WB_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_rd_we |-> $past(mem_rsp_valid)); // R10

  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_rd_we && (mem_req_size == 2'd0) |-> (wb_rd_data[31:8] == 24'd0)); // R2
endmodule

bind ld_fmt_unit ldf_checker #(.RIDX_W(RIDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
  .mem_rsp_valid(mem_rsp_valid), .wb_valid(wb_valid), .wb_rd_we(wb_rd_we),
  .wb_rd_idx(wb_rd_idx), .wb_rd_data(wb_rd_data), .wb_ra_we(wb_ra_we),
  .wb_ra_idx(wb_ra_idx), .wb_misalign(wb_misalign), .wb_illegal(wb_illegal)
);

// File: tb/sim_ld_fmt_unit.sv
`timescale 1ns/1ps
module sim_ld_fmt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_kind = '0, in_mode = '0;
  logic        in_update = 1'b0;
  logic [4:0]  in_ra = '0, in_rd = '0;
  logic [31:0] in_base = '0, in_index = '0;
  logic [15:0] in_disp = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        wb_valid, wb_rd_we, wb_ra_we, wb_misalign, wb_illegal;
  logic [4:0]  wb_rd_idx, wb_ra_idx;
  logic [31:0] wb_rd_data, wb_ra_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ld_fmt_unit u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] x_ea(int m, logic [31:0] b, logic [31:0] x, logic [15:0] d);
    logic [31:0] dd;
    dd = $signed(d);
    if (m == 0) return b + dd;
    if (m == 1) return b + x;
    return b;
  endfunction

  function automatic logic [31:0] x_fmt(int k, logic [31:0] a, logic [31:0] w);
    logic [31:0] h;
    h = a[1] ? (w & 32'hFFFF) : (w >> 16);
    case (k)
      0: return (w >> (8 * (3 - a[1:0]))) & 32'hFF;
      1: return h;
      2: return h[15] ? (h | 32'hFFFF0000) : h;
      default: return w;
    endcase
  endfunction

  function automatic bit x_mis(int k, logic [31:0] a);
    if (k == 3) return a[1:0] != 0;
    if (k == 0) return 0;
    return a[0];
  endfunction

  task automatic run_load(input int k, input int m, input bit upd, input logic [4:0] ra,
                          input logic [4:0] rd, input logic [31:0] b, input logic [31:0] x,
                          input logic [15:0] d, input logic [31:0] w, input int qd, input int pd);
    logic [31:0] ea, exp;
    bit mis, ill;
    string tk;
    ea  = x_ea(m, b, x, d);
    mis = x_mis(k, ea);
    ill = upd && (ra == 0 || ra == rd);
    exp = x_fmt(k, ea, w);
    tk  = (k == 0) ? "R2" : (k == 1) ? "R3" : (k == 2) ? "R4" : "R5";
    @(negedge clk);
    chk(in_ready === 1'b1, "R9 ready before accept", {31'd0, in_ready}, 1);
    in_valid = 1; in_kind = k[1:0]; in_mode = m[1:0]; in_update = upd;
    in_ra = ra; in_rd = rd; in_base = b; in_index = x; in_disp = d;
    @(negedge clk);
    in_valid = 0; in_base = $urandom; in_index = $urandom; in_disp = $urandom;
    if (mis || ill) begin
      chk(wb_valid === 1'b1 && mem_req_valid === 1'b0, "R10 fault completes next cycle",
          {30'd0, wb_valid, mem_req_valid}, 32'd2);
      chk(wb_misalign === mis, "R7 misalign flag", {31'd0, wb_misalign}, {31'd0, mis});
      chk(wb_illegal === ill, "R8 illegal flag", {31'd0, wb_illegal}, {31'd0, ill});
      chk(wb_rd_we === 1'b0 && wb_ra_we === 1'b0, "R7 R8 no write on fault",
          {30'd0, wb_rd_we, wb_ra_we}, 0);
    end else begin
      for (int i = 0; i <= qd; i++) begin
        chk(mem_req_valid === 1'b1 && in_ready === 1'b0 && wb_valid === 1'b0, "R9 request pending",
            {29'd0, mem_req_valid, in_ready, wb_valid}, 32'd4);
        chk(mem_req_addr === ea, "R1 request address", mem_req_addr, ea);
        chk(mem_req_size === ((k == 0) ? 2'd0 : (k == 3) ? 2'd2 : 2'd1), "R9 request size",
            {30'd0, mem_req_size}, k);
        if (i == qd) mem_req_ready = 1;
        @(negedge clk);
      end
      mem_req_ready = 0;
      for (int i = 0; i < pd; i++) begin
        chk(mem_req_valid === 1'b0 && wb_valid === 1'b0, "R10 waiting on response",
            {30'd0, mem_req_valid, wb_valid}, 0);
        mem_rsp_data = $urandom;
        @(negedge clk);
      end
      mem_rsp_valid = 1; mem_rsp_data = w;
      @(negedge clk);
      mem_rsp_valid = 0; mem_rsp_data = $urandom;
      chk(wb_valid === 1'b1 && wb_rd_we === 1'b1, "R10 completion after response",
          {30'd0, wb_valid, wb_rd_we}, 3);
      chk(wb_rd_data === exp, tk, wb_rd_data, exp);
      chk(wb_rd_idx === rd, "R6 destination index", {27'd0, wb_rd_idx}, {27'd0, rd});
      chk(wb_ra_we === upd, "R6 base write enable", {31'd0, wb_ra_we}, {31'd0, upd});
      if (upd) chk(wb_ra_data === ea && wb_ra_idx === ra, "R6 base write value", wb_ra_data, ea);
      chk(wb_misalign === 1'b0 && wb_illegal === 1'b0, "R7 no flag when aligned",
          {30'd0, wb_misalign, wb_illegal}, 0);
    end
    @(negedge clk);
    chk(wb_valid === 1'b0 && in_ready === 1'b1, "R10 one-cycle completion",
        {30'd0, wb_valid, in_ready}, 1);
  endtask

  initial begin
    void'($urandom(32'd7117));
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && mem_req_valid === 1'b0 && wb_valid === 1'b0, "R11 reset state",
        {29'd0, in_ready, mem_req_valid, wb_valid}, 32'd4);
    rst_n = 1;
    @(negedge clk);
    // a response while idle is ignored
    mem_rsp_valid = 1; @(negedge clk); mem_rsp_valid = 0;
    chk(wb_valid === 1'b0 && in_ready === 1'b1, "R10 stray response ignored",
        {30'd0, wb_valid, in_ready}, 1);
    // directed corner cases
    run_load(0, 0, 0, 5'd3, 5'd4, 32'h1000, 0, 16'h0001, 32'hA1B2C3D4, 0, 0); // R2 lane 1
    run_load(0, 1, 0, 5'd3, 5'd4, 32'h1000, 32'd3, 0, 32'hA1B2C3D4, 1, 2);   // R2 lane 3
    run_load(2, 0, 0, 5'd3, 5'd4, 32'h1004, 0, 16'hFFFE, 32'h12348765, 0, 0); // R4 low half neg
    run_load(1, 2, 0, 5'd3, 5'd4, 32'h2000, 32'h55, 16'h7, 32'h9ABC0011, 2, 1); // R3 base only
    run_load(3, 0, 1, 5'd7, 5'd9, 32'h0, 0, 16'hFFFC, 32'hDEADBEEF, 0, 3);   // R5 R6 wrap
    run_load(3, 1, 0, 5'd3, 5'd4, 32'h100, 32'h2, 0, 32'h0, 0, 0);           // R7 word
    run_load(1, 0, 0, 5'd3, 5'd4, 32'h100, 0, 16'h3, 32'h0, 0, 0);           // R7 half
    run_load(0, 0, 1, 5'd0, 5'd4, 32'h100, 0, 0, 32'h0, 0, 0);              // R8 ra zero
    run_load(0, 0, 1, 5'd6, 5'd6, 32'h100, 0, 0, 32'h0, 0, 0);              // R8 ra==rd
    run_load(3, 3, 1, 5'd6, 5'd6, 32'h101, 0, 0, 32'h0, 0, 0);              // R7 R8 both
    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] b, x;
      logic [15:0] d;
      logic [4:0] ra, rd;
      b = $urandom; x = $urandom; d = $urandom;
      if ($urandom_range(0, 1) == 1) begin b[1:0] = 0; x[1:0] = 0; d[1:0] = 0; end
      ra = $urandom; rd = ($urandom_range(0, 7) == 0) ? ra : 5'($urandom);
      run_load($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3) == 0,
               ra, rd, b, x, d, $urandom, $urandom_range(0, 3), $urandom_range(0, 3));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule